// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block is the host side of a two-wire PHY management link. A host presents a PHY address, a register address, a direction flag and, for writes, a data word. It then pulses a request. The block builds the complete frame and shifts it out one bit per management clock period. It raises a busy flag while the frame runs. At the end it gives a one-cycle completion pulse and, for a read, the 16-bit word captured from the PHY.

The block drives three signals toward the pad: the management clock, the serial data out and the data output enable. It reads the serial data in. The output enable changes bit by bit, so the pad is released during turnaround, during the data phase of a read and during one closing clock period. Each half of the management clock lasts a parameterised number of system clocks, and that number must be at least 2.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: Bit times 0 to 31 of every frame carry a 1 with the output enable high.
- R2: Bit times 32 and 33 carry 0 then 1. Bit times 34 and 35 carry the opcode: 1 then 0 for a read (`wr`=0), 0 then 1 for a write (`wr`=1). The output enable is high for all four.
- R3: Bit times 36 to 40 carry the PHY address, MSB first, and bit times 41 to 45 carry the register address, MSB first, all with the output enable high.
- R4: In a write, bit times 46 and 47 have the output enable low and data out 0. Bit times 48 to 63 then carry the write word MSB first with the output enable high.
- R5: In a read, the output enable is low and data out is 0 from bit time 46 to the end of the frame. `rdata` holds the serial input sampled in bit times 48 to 63, first sample in bit 15. The input during bit times 46 and 47 has no effect on `rdata`.
- R6: Data out and output enable change only when the management clock falls or while it is low. They are stable for the whole high half. The serial input is sampled at the system clock edge that ends the high half.
- R7: Bit time 64 is one extra clock period with the output enable low. When the frame ends, the management clock, data out and output enable are all 0.
- R8: `busy` goes high on the cycle after a request is accepted and stays high until completion. `done` is a one-cycle pulse issued with `busy` already low, and `rdata` is valid at that pulse.
- R9: A request raised while `busy` is high is ignored. The running frame is unchanged and no second frame follows.
- R10: Each low half and each high half of the management clock lasts DIV system clocks, so `busy` is high for exactly 130*DIV cycles per frame.
- R11: After reset, `busy`, `done`, the management clock, data out, output enable and `rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a frame when idle |
| wr | input | 1 | 1 = write frame, 0 = read frame |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address within the PHY |
| wdata | input | 16 | Word to write |
| rdata | output | 16 | Word captured by the last read |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Serial data toward the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Serial data from the pad |

## Verification
A vector table runs write and read frames. Writes use data words with a single bit at the top, and also a mixed pattern, which shows whether the data field is shifted out MSB first and lined up on the correct bit time. Reads use asymmetric patterns, including a lone low bit and all zeros while the input is held high during turnaround and idle bits. These reveal whether a capture is off by one and whether the turnaround bits are sampled. Directed tests cover the reset state, a request raised in the middle of a frame, and the idle state after completion. Every frame is also timed half-period by half-period.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int PRE_LEN  = 32;
  // preamble, start pair, opcode pair, two addresses, turnaround, data
  localparam int FRAME_BITS = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TOTAL_BITS = FRAME_BITS + 1;          // plus closing idle bit
  localparam int TA_POS     = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_POS   = TA_POS + 2;
  localparam int IDX_W      = $clog2(TOTAL_BITS + 1);

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_WRITE   = 2'b01;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic              din,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)         word <= '0;
    else if (sample) word <= {word[DATA_W-2:0], din};
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic              busy,
  output logic              done,
  output logic              mdc,
  output logic              mdo,
  output logic              mdio_oe,
  output logic              sample
);
  localparam logic [IDX_W-1:0] TA_I    = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_I  = IDX_W'(DATA_POS);
  localparam logic [IDX_W-1:0] FINAL_I = IDX_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame_new;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W-1:0]      idx_n;
  logic                  is_rd;
  logic                  oe_n;

  assign frame_new = {{PRE_LEN{1'b1}}, START_CODE, (wr ? OP_WRITE : OP_READ),
                      phy_addr, reg_addr, 2'b00, wdata};
  assign idx_n = idx + 1'b1;

  // output enable of the bit time that follows the current one
  always_comb begin
    if (idx_n < TA_I)         oe_n = 1'b1;
    else if (idx_n < DATA_I)  oe_n = 1'b0;
    else if (idx_n < FINAL_I) oe_n = !is_rd;
    else                      oe_n = 1'b0;
  end

  assign sample = busy && tick && mdc && is_rd && (idx >= DATA_I) && (idx < FINAL_I);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      mdc     <= 1'b0;
      mdo     <= 1'b0;
      mdio_oe <= 1'b0;
      idx     <= '0;
      is_rd   <= 1'b0;
      shreg   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy    <= 1'b1;
          is_rd   <= !wr;
          idx     <= '0;
          mdc     <= 1'b0;
          mdo     <= frame_new[FRAME_BITS-1];
          mdio_oe <= 1'b1;
          shreg   <= frame_new << 1;
        end
      end else if (tick) begin
        if (!mdc) begin
          mdc <= 1'b1;
        end else begin
          mdc <= 1'b0;
          if (idx == FINAL_I) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdo     <= 1'b0;
            mdio_oe <= 1'b0;
          end else begin
            idx     <= idx_n;
            mdio_oe <= oe_n;
            mdo     <= shreg[FRAME_BITS-1] & oe_n;
            shreg   <= shreg << 1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine #(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        wr,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdo,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic tick;
  logic sample;

  if (DIV < 2) begin : g_bad_div
    initial $error("DIV must be at least 2");
  end

  mdio_half_timer #(.DIV(DIV)) u_timer (
    .clk (clk), .rst (rst), .run (busy), .tick (tick)
  );

  mdio_frame_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .wr       (wr),
    .phy_addr (phy_addr),
    .reg_addr (reg_addr),
    .wdata    (wdata),
    .tick     (tick),
    .busy     (busy),
    .done     (done),
    .mdc      (mdc),
    .mdo      (mdo),
    .mdio_oe  (mdio_oe),
    .sample   (sample)
  );

  mdio_rx_shift #(.DATA_W(mdio_pkg::DATA_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .sample (sample),
    .din    (mdio_i),
    .word   (rdata)
  );
endmodule

// File: rtl/mdio_mgmt_engine_chk.sv
module mdio_mgmt_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdo,
  input logic        mdio_oe,
  input logic [15:0] rdata
);
  // R6: pad drive is frozen while the management clock is high
  p_stable_high_r6: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdo) && $stable(mdio_oe)));

  // R7: an idle engine leaves the pad released with clock and data low
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdo && !mdio_oe));

  // R8: completion pulse lasts one cycle and busy has dropped by then
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R5: the captured word only moves while a frame runs
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(rdata));

  // R11: outputs are cleared right after reset
  p_reset_clear_r11: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && !mdc && !mdio_oe && rdata == 16'h0));
endmodule

bind mdio_mgmt_engine mdio_mgmt_engine_chk u_chk (
  .clk (clk), .rst (rst), .busy (busy), .done (done), .mdc (mdc),
  .mdo (mdo), .mdio_oe (mdio_oe), .rdata (rdata)
);

// File: tb/mdio_mgmt_engine_test.sv
`timescale 1ns/1ps
module mdio_mgmt_engine_test;
  localparam int DIV = 4;
  localparam int NVEC = 5;
  // {read, phy, reg, wdata, read pattern}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b0, 5'h01, 5'h00, 16'h8000, 16'h0000},
    {1'b1, 5'h1F, 5'h12, 16'h0000, 16'hA5C3},
    {1'b0, 5'h10, 5'h01, 16'h1234, 16'h0000},
    {1'b1, 5'h00, 5'h1F, 16'hFFFF, 16'h0001},
    {1'b1, 5'h03, 5'h04, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic wr = 1'b0;
  logic [4:0] phy_addr = '0;
  logic [4:0] reg_addr = '0;
  logic [15:0] wdata = '0;
  logic mdio_i = 1'b1;
  logic [15:0] rdata;
  logic busy, done, mdc, mdo, mdio_oe;

  int total = 0;
  int bad = 0;
  logic [64:0] got_mdo, got_oe;
  int rises, busy_cyc, phase_err, last_run, hi_chg;

  always #2.5 clk = ~clk;

  mdio_mgmt_engine #(.DIV(DIV)) uut (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata), .busy(busy),
    .done(done), .mdc(mdc), .mdo(mdo), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5ns * 60000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] rp, input bit inject);
    logic prev;
    logic prev_mdo;
    int run_len, bitn, cyc;
    @(negedge clk);
    req = 1'b1; wr = !rd; phy_addr = pa; reg_addr = ra; wdata = wd; mdio_i = 1'b1;
    got_mdo = '0; got_oe = '0; rises = 0; busy_cyc = 0; phase_err = 0; hi_chg = 0;
    prev = 1'b0; prev_mdo = 1'b0; run_len = 0; bitn = 0; cyc = 0;
    forever begin
      @(negedge clk);
      req = 1'b0;
      if (inject && cyc == 200) begin
        req = 1'b1; wr = 1'b1; phy_addr = 5'h0A; reg_addr = 5'h15; wdata = 16'h5A5A;
      end
      cyc++;
      if (done) break;
      if (busy) busy_cyc++;
      if (mdc != prev) begin
        if (run_len != DIV) phase_err++;
        run_len = 1;
        if (mdc) begin
          if (rises <= 64) begin
            got_mdo[64 - rises] = mdo;
            got_oe[64 - rises]  = mdio_oe;
          end
          rises++;
        end else begin
          bitn++;
          mdio_i = (bitn >= 48 && bitn <= 63) ? rp[63 - bitn] : 1'b1;
        end
      end else begin
        run_len++;
        if (mdc && mdo != prev_mdo) hi_chg++;
      end
      prev = mdc;
      prev_mdo = mdo;
      if (cyc > 2000) break;
    end
    last_run = run_len;
  endtask

  initial begin
    logic [64:0] exp_mdo, exp_oe;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset outputs", {90'h0, busy, done, mdc, mdo, mdio_oe, 1'b0}, 96'h0);
    check("R11 reset rdata", {80'h0, rdata}, 96'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic rd;
      logic [4:0] pa, ra;
      logic [15:0] wd, rp;
      {rd, pa, ra, wd, rp} = VEC[v];
      run_frame(rd, pa, ra, wd, rp, 1'b0);
      exp_mdo = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b00,
                 (rd ? 16'h0 : wd), 1'b0};
      exp_oe  = {32'hFFFF_FFFF, 4'hF, 10'h3FF, 2'b00, (rd ? 16'h0 : 16'hFFFF), 1'b0};
      // R1 R2 R3 preamble, start, opcode, addresses
      check("R1 preamble", {64'h0, exp_mdo[64:33] ^ got_mdo[64:33]}, 96'h0);
      check("R2 start and opcode", {92'h0, got_mdo[32:29]}, {92'h0, exp_mdo[32:29]});
      check("R3 addresses", {86'h0, got_mdo[28:19]}, {86'h0, exp_mdo[28:19]});
      // R4 R5 turnaround and data field, R7 closing bit
      if (rd) check("R5 read drive", {31'h0, got_mdo}, {31'h0, exp_mdo});
      else    check("R4 write drive", {31'h0, got_mdo}, {31'h0, exp_mdo});
      check("R7 R1 R4 R5 output enable per bit", {31'h0, got_oe}, {31'h0, exp_oe});
      check("R10 clock rises per frame", 96'(rises), 96'd65);
      check("R10 half periods", {64'h0, 32'(phase_err), 32'(last_run)}, {64'h0, 32'd0, 32'(DIV)});
      check("R6 data stable while clock high", 96'(hi_chg), 96'd0);
      check("R8 R10 busy length", 96'(busy_cyc), 96'(130 * DIV));
      check("R8 R7 state at done", {91'h0, busy, mdc, mdo, mdio_oe, done}, {91'h0, 5'b00001});
      if (rd) check("R5 captured word", {80'h0, rdata}, {80'h0, rp});
      @(negedge clk);
      check("R8 done single cycle", {95'h0, done}, 96'h0);
    end

    // R9: request during a frame is ignored
    run_frame(1'b1, 5'h11, 5'h02, 16'h0, 16'h3C96, 1'b1);
    exp_mdo = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h11, 5'h02, 2'b00, 16'h0, 1'b0};
    check("R9 running frame unchanged", {31'h0, got_mdo}, {31'h0, exp_mdo});
    check("R9 rdata of running frame", {80'h0, rdata}, {80'h0, 16'h3C96});
    begin
      int act = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (busy || mdc || mdio_oe) act++;
      end
      check("R9 no second frame", 96'(act), 96'd0);
    end
    finish_run();
  end
endmodule